// File: doc/BRIEF.md
# Packed Integer Vector Arithmetic Unit

This block is a 256-bit packed-integer datapath. It accepts two wide operands and splits them into lanes. It applies one operation per accepted request and returns a 256-bit result one clock later. The opcode selects the operation. A two-bit size code selects the lane width for the operations that support more than one width. An eight-bit count drives the shift operations.

The supported operations are:
- wrapping lane-wise addition;
- signed 16-bit multiplication, returning either the low or the high half of each product;
- logical left and right shifts by a uniform count;
- a 16-bit pairwise horizontal sum that packs the sums from both operands within each 128-bit half.

Lane 0 is always the least significant field of every vector.

The unit is fully pipelined with a depth of one. A new request can be accepted on every clock. An opcode or opcode/size pair that the unit does not support produces a zero result and raises a flag alongside the valid strobe.

Top module: `simd_int_alu`

## Requirements
- R1: Opcode 0 adds the operands lane by lane with wraparound and no carry across lanes. Size code 0 selects 8-bit lanes, 1 selects 16-bit lanes and 2 selects 32-bit lanes.
- R2: Opcode 1 multiplies each pair of 16-bit lanes as signed numbers and keeps product bits 15:0.
- R3: Opcode 2 multiplies each pair of 16-bit lanes as signed numbers into a 32-bit product and keeps bits 31:16.
- R4: Opcode 3 shifts each lane of operand a right, filling with zeros. Opcode 4 shifts each lane of operand a left, filling with zeros. Size code 1 selects 16-bit lanes, 2 selects 32-bit lanes and 3 selects 64-bit lanes.
- R5: A shift count greater than or equal to the lane width yields an all-zero lane.
- R6: Opcode 5 produces 16-bit results r0..r15, where 16-bit lane k is bits 16k+15:16k. Each 128-bit half h (lanes 8h..8h+7) gets the following results:
  - results 8h..8h+3 are a[8h+2j]+a[8h+2j+1] for j = 0..3;
  - results 8h+4..8h+7 are the same pairwise sums taken from b.
- R7: Lane index 0 always occupies the least significant bits of both operands and the result.
- R8: A request presented with in_valid is reflected on result, with result_valid high, exactly one clock later. Without in_valid, result_valid is low the next clock and result keeps its value.
- R9: The following requests return an all-zero result with illegal_op high for that one result cycle:
  - opcodes 6 and 7;
  - opcode 0 with size code 3;
  - opcodes 3 and 4 with size code 0.
- R10: Synchronous active-high reset clears result, result_valid and illegal_op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 3 | Operation select |
| size_sel | input | 2 | Lane width code |
| shamt | input | 8 | Shift count |
| op_a | input | 256 | First operand |
| op_b | input | 256 | Second operand |
| result | output | 256 | Registered result |
| result_valid | output | 1 | Result strobe, one clock after in_valid |
| illegal_op | output | 1 | Unsupported request flag |

## Verification
The bench targets lanes that overflow, such as 0xFF+0x01 in every byte. A design that leaked carries would corrupt the neighbouring lane.

It multiplies -32768 by -32768 and mixes signs. Treating the operands as unsigned, or returning the wrong half, changes the upper half of the product.

It applies shift counts exactly at the lane width and one below it. It also shifts negative lanes right, where an arithmetic fill would show up as ones.

The horizontal sum uses distinct lane values, so any misordering of the sums or mixing of the halves is visible. Illegal combinations and idle cycles are checked for a non-zero result, a missing flag or a result that changes without a request.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_MULLO = 3'd1,
      OP_MULHI = 3'd2,
      OP_SRL   = 3'd3,
      OP_SLL   = 3'd4,
      OP_HADD  = 3'd5
   } simd_op_e;

   localparam logic [1:0] SZ_8  = 2'd0;
   localparam logic [1:0] SZ_16 = 2'd1;
   localparam logic [1:0] SZ_32 = 2'd2;
   localparam logic [1:0] SZ_64 = 2'd3;

   localparam int SLICE_W = 128;
   localparam int WORD_W  = 16;
endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add #(
   parameter int VEC_W = 256
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  logic [1:0]       size_sel,
   output logic [VEC_W-1:0] y
);
   localparam int NUM_SZ = 3;

   if (VEC_W % 32 != 0) begin : g_chk
      $error("simd_lane_add: VEC_W must be a multiple of 32");
   end

   logic [NUM_SZ-1:0][VEC_W-1:0] sums;

   for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
      localparam int EW = 8 << s;
      localparam int NE = VEC_W / EW;
      for (genvar e = 0; e < NE; e++) begin : g_lane
         assign sums[s][e*EW +: EW] = a[e*EW +: EW] + b[e*EW +: EW];
      end
   end

   always_comb begin
      case (size_sel)
         2'd0:    y = sums[0];
         2'd1:    y = sums[1];
         2'd2:    y = sums[2];
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
   parameter int VEC_W  = 256,
   parameter int ELEM_W = 16
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  logic             hi_sel,
   output logic [VEC_W-1:0] y
);
   localparam int NE = VEC_W / ELEM_W;
   localparam int PW = 2 * ELEM_W;

   if (VEC_W % ELEM_W != 0) begin : g_chk
      $error("simd_mul16: VEC_W must be a multiple of ELEM_W");
   end

   for (genvar e = 0; e < NE; e++) begin : g_lane
      logic signed [PW-1:0] prod;
      assign prod = $signed(a[e*ELEM_W +: ELEM_W]) * $signed(b[e*ELEM_W +: ELEM_W]);
      assign y[e*ELEM_W +: ELEM_W] = hi_sel ? prod[PW-1:ELEM_W] : prod[ELEM_W-1:0];
   end
endmodule

// File: rtl/simd_shift.sv
module simd_shift #(
   parameter int VEC_W = 256,
   parameter int CNT_W = 8
) (
   input  logic [VEC_W-1:0] a,
   input  logic [CNT_W-1:0] cnt,
   input  logic [1:0]       size_sel,
   input  logic             left,
   output logic [VEC_W-1:0] y
);
   localparam int NUM_SZ = 3;

   if (VEC_W % 64 != 0 || CNT_W < 1) begin : g_chk
      $error("simd_shift: VEC_W must be a multiple of 64 and CNT_W positive");
   end

   logic [NUM_SZ-1:0][VEC_W-1:0] res;

   for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
      localparam int EW = 16 << s;
      localparam int NE = VEC_W / EW;
      localparam logic [CNT_W:0] LIM = (CNT_W+1)'(EW);
      logic too_far;
      assign too_far = {1'b0, cnt} >= LIM;
      for (genvar e = 0; e < NE; e++) begin : g_lane
         logic [EW-1:0] src;
         assign src = a[e*EW +: EW];
         assign res[s][e*EW +: EW] = too_far ? '0 : (left ? (src << cnt) : (src >> cnt));
      end
   end

   always_comb begin
      case (size_sel)
         2'd1:    y = res[0];
         2'd2:    y = res[1];
         2'd3:    y = res[2];
         default: y = '0;
      endcase
   end

   always_comb begin
      if (size_sel == 2'd1 && {1'b0, cnt} >= (CNT_W+1)'(16))
         AST_WIDE_COUNT_ZERO: assert (y == '0); // R5
   end
endmodule

// File: rtl/simd_hadd16.sv
module simd_hadd16 #(
   parameter int VEC_W = 256
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   output logic [VEC_W-1:0] y
);
   import simd_alu_pkg::*;
   localparam int HALVES = VEC_W / SLICE_W;
   localparam int PER_H  = SLICE_W / WORD_W;
   localparam int PAIRS  = PER_H / 2;

   if (VEC_W % SLICE_W != 0) begin : g_chk
      $error("simd_hadd16: VEC_W must be a multiple of 128");
   end

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      for (genvar j = 0; j < PAIRS; j++) begin : g_pair
         localparam int SRC = h*PER_H + 2*j;
         assign y[(h*PER_H + j)*WORD_W +: WORD_W] =
            a[SRC*WORD_W +: WORD_W] + a[(SRC+1)*WORD_W +: WORD_W];
         assign y[(h*PER_H + PAIRS + j)*WORD_W +: WORD_W] =
            b[SRC*WORD_W +: WORD_W] + b[(SRC+1)*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu #(
   parameter int VEC_W = 256,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [2:0]       opcode,
   input  logic [1:0]       size_sel,
   input  logic [CNT_W-1:0] shamt,
   input  logic [VEC_W-1:0] op_a,
   input  logic [VEC_W-1:0] op_b,
   output logic [VEC_W-1:0] result,
   output logic             result_valid,
   output logic             illegal_op
);
   import simd_alu_pkg::*;

   if (VEC_W % SLICE_W != 0) begin : g_chk
      $error("simd_int_alu: VEC_W must be a multiple of 128");
   end

   simd_op_e op;
   assign op = simd_op_e'(opcode);

   logic [VEC_W-1:0] add_y, mul_y, shf_y, hadd_y;
   logic [VEC_W-1:0] next_y;
   logic             bad;

   simd_lane_add #(.VEC_W(VEC_W)) u_add (
      .a(op_a), .b(op_b), .size_sel(size_sel), .y(add_y)
   );

   simd_mul16 #(.VEC_W(VEC_W), .ELEM_W(WORD_W)) u_mul (
      .a(op_a), .b(op_b), .hi_sel(op == OP_MULHI), .y(mul_y)
   );

   simd_shift #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_shf (
      .a(op_a), .cnt(shamt), .size_sel(size_sel), .left(op == OP_SLL), .y(shf_y)
   );

   simd_hadd16 #(.VEC_W(VEC_W)) u_hadd (
      .a(op_a), .b(op_b), .y(hadd_y)
   );

   always_comb begin
      bad    = 1'b0;
      next_y = '0;
      case (op)
         OP_ADD: begin
            bad    = (size_sel == SZ_64);
            next_y = add_y;
         end
         OP_MULLO, OP_MULHI: next_y = mul_y;
         OP_SRL, OP_SLL: begin
            bad    = (size_sel == SZ_8);
            next_y = shf_y;
         end
         OP_HADD: next_y = hadd_y;
         default: bad = 1'b1;
      endcase
      if (bad) next_y = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         result       <= '0;
         result_valid <= 1'b0;
         illegal_op   <= 1'b0;
      end else begin
         result_valid <= in_valid;
         illegal_op   <= in_valid & bad;
         if (in_valid) result <= next_y;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> result_valid); // R8
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !result_valid); // R8
   AST_IDLE_HOLDS:    assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result)); // R8
   AST_ILLEGAL_ZERO:  assert property (@(posedge clk) disable iff (rst) illegal_op |-> (result == '0)); // R9
   AST_ILLEGAL_VALID: assert property (@(posedge clk) disable iff (rst) illegal_op |-> result_valid); // R9
   AST_RESET_CLEAR:   assert property (@(posedge clk) rst |=> (!result_valid && result == '0)); // R10
endmodule

// File: tb/sim_simd_int_alu.sv
module sim_simd_int_alu;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 256;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [2:0]    opcode = '0;
   logic [1:0]    size_sel = '0;
   logic [7:0]    shamt = '0;
   logic [VW-1:0] op_a = '0;
   logic [VW-1:0] op_b = '0;
   logic [VW-1:0] result;
   logic          result_valid;
   logic          illegal_op;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_int_alu u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
      .size_sel(size_sel), .shamt(shamt), .op_a(op_a), .op_b(op_b),
      .result(result), .result_valid(result_valid), .illegal_op(illegal_op)
   );

   function automatic logic [VW-1:0] model(input logic [2:0] opc, input logic [1:0] es,
                                           input logic [7:0] sh, input logic [VW-1:0] a,
                                           input logic [VW-1:0] b, output bit ill);
      logic [VW-1:0] r = '0;
      int w;
      logic [63:0] mask, ea, eb, er;
      ill = 1'b0;
      case (opc)
         3'd0, 3'd3, 3'd4: begin
            if ((opc == 3'd0 && es == 2'd3) || (opc != 3'd0 && es == 2'd0)) ill = 1'b1;
            else begin
               w = 8 << es;
               mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
               for (int i = 0; i < VW / w; i++) begin
                  ea = 64'(a >> (i*w)) & mask;
                  eb = 64'(b >> (i*w)) & mask;
                  if (opc == 3'd0) er = (ea + eb) & mask;
                  else if (int'(sh) >= w) er = '0;
                  else if (opc == 3'd3) er = ea >> sh;
                  else er = (ea << sh) & mask;
                  r = r | (VW'(er) << (i*w));
               end
            end
         end
         3'd1, 3'd2: begin
            for (int i = 0; i < 16; i++) begin
               int p;
               p = int'($signed(a[i*16 +: 16])) * int'($signed(b[i*16 +: 16]));
               r[i*16 +: 16] = (opc == 3'd1) ? p[15:0] : p[31:16];
            end
         end
         3'd5: begin
            for (int k = 0; k < 16; k++) begin
               int h = k / 8;
               int j = k % 8;
               int idx = h*8 + 2*(j % 4);
               logic [VW-1:0] src = (j < 4) ? a : b;
               r[k*16 +: 16] = src[idx*16 +: 16] + src[(idx+1)*16 +: 16];
            end
         end
         default: ill = 1'b1;
      endcase
      if (ill) r = '0;
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                        input logic [VW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] opc, input logic [1:0] es, input bit ill);
      if (ill) return "R9";
      case (opc)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd5: return "R6";
         default: return "R4";
      endcase
   endfunction

   task automatic run(input logic [2:0] opc, input logic [1:0] es, input logic [7:0] sh,
                      input logic [VW-1:0] a, input logic [VW-1:0] b, input string req);
      bit ill;
      logic [VW-1:0] exp;
      logic [VW-1:0] held;
      exp = model(opc, es, sh, a, b, ill);
      @(negedge clk);
      in_valid = 1'b1; opcode = opc; size_sel = es; shamt = sh; op_a = a; op_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      op_a = ~a; op_b = ~b;
      check(result == exp, (req == "") ? req_of(opc, es, ill) : req, result, exp);
      check(result_valid == 1'b1 && illegal_op == ill, "R8 strobe/R9 flag",
            VW'({result_valid, illegal_op}), VW'({1'b1, ill}));
      held = result;
      @(negedge clk);
      check(result_valid == 1'b0 && result == held, "R8 hold", result, held);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] ra, rb, seq;
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) seq[i*16 +: 16] = 16'(i + 1) * 16'h0101;

      // R10: drive garbage while reset is high, then check the cleared outputs
      @(negedge clk);
      in_valid = 1'b1; op_a = '1; op_b = '1;
      @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(result == '0 && !result_valid && !illegal_op, "R10", result, '0);
      rst = 1'b0;
      @(negedge clk);

      // R1: per-lane wraparound with no carry into the neighbour lane
      run(3'd0, 2'd0, 8'd0, {32{8'hFF}}, {32{8'h01}}, "R1");
      run(3'd0, 2'd1, 8'd0, {16{16'hFFFF}}, {16{16'h0002}}, "R1");
      run(3'd0, 2'd2, 8'd0, {8{32'hFFFF_FFFF}}, {8{32'h0000_0001}}, "R1");

      // R2/R3: signed extremes and mixed signs
      run(3'd2, 2'd0, 8'd0, {16{16'h8000}}, {16{16'h8000}}, "R3");
      run(3'd2, 2'd0, 8'd0, {16{16'hFFFF}}, {16{16'h0003}}, "R3");
      run(3'd1, 2'd0, 8'd0, {16{16'h8001}}, {16{16'h7FFF}}, "R2");

      // R4/R5: logical fill on negative lanes and counts at the lane width
      run(3'd3, 2'd1, 8'd15, {16{16'h8000}}, '0, "R4");
      run(3'd3, 2'd1, 8'd16, {16{16'hFFFF}}, '0, "R5");
      run(3'd4, 2'd2, 8'd32, {8{32'h1234_5678}}, '0, "R5");
      run(3'd4, 2'd3, 8'd63, {4{64'h1}}, '0, "R4");
      run(3'd3, 2'd3, 8'd64, {4{64'hFFFF_FFFF_FFFF_FFFF}}, '0, "R5");
      run(3'd3, 2'd2, 8'd255, {8{32'hDEAD_BEEF}}, '0, "R5");

      // R6/R7: distinct lanes expose ordering and half packing
      run(3'd5, 2'd0, 8'd0, seq, ~seq, "R6");
      run(3'd0, 2'd1, 8'd0, VW'(16'h0001), '0, "R7");

      // R9: unsupported combinations
      run(3'd6, 2'd0, 8'd0, '1, '1, "R9");
      run(3'd7, 2'd2, 8'd0, '1, '1, "R9");
      run(3'd0, 2'd3, 8'd0, '1, '1, "R9");
      run(3'd3, 2'd0, 8'd1, '1, '1, "R9");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         logic [2:0] opc;
         logic [1:0] es;
         logic [7:0] sh;
         for (int k = 0; k < 8; k++) begin
            ra[k*32 +: 32] = $urandom;
            rb[k*32 +: 32] = $urandom;
         end
         opc = ($urandom % 10 == 0) ? 3'($urandom) : 3'($urandom % 6);
         es  = 2'($urandom);
         sh  = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 70);
         run(opc, es, sh, ra, rb, "");
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule